// File: doc/BRIEF.md
# Three-Stage Pipeline Control Sequencer

This block steers a fetch, decode and execute pipeline. Every cycle it knows which instruction sits in each of the three stages. From the class of the instruction in execute, and from how far that instruction has progressed, it drives the per-cycle datapath controls: register-file read and write strobes, the source of the address register, store-data drive, load-data capture, link-register save and correction, and a flush of the front stages. It also keeps the fetch address register (the PC) and a link value. Decoding beyond a three-bit class code is left to the datapath, as are the ALU, the shifter and the memories.

Instructions arrive on a valid/ready stream. A word is taken on any cycle where `in_valid` and `in_ready` are both high. `in_ready` is computed from pipeline state only and never depends on `in_valid`. A sender that sees `in_ready` low must hold its word and present it again; nothing is lost. When `in_ready` is high and `in_valid` is low, a bubble enters fetch.

The class code in an instruction sets how long it stays in execute. An ALU instruction takes one cycle, a store takes two, and a load or a branch takes three. While an instruction is still short of its last execute cycle, the front of the pipeline is frozen. The one exception is the refill that follows a branch.

Top module: `pipe_seq`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, all three stage-valid flags are 0, `pc` and `lr_val` are 0, every control strobe is 0 and `in_ready` is 1.
- R2: A word accepted in cycle N appears with its word in fetch in cycle N+1, in decode in cycle N+2 and in execute in cycle N+3. Back-to-back ALU instructions leave execute at one per cycle.
- R3: Class codes: 0 = ALU, 1 = load, 2 = store, 3 = branch, 4 = branch-with-link. Codes 5 to 7 are handled as ALU. An ALU instruction spends one execute cycle, with `rf_rd` and `rf_wr` both high and `addr_sel` at 0.
- R4: A store spends two execute cycles. In step 0, `rf_rd` is high and `addr_sel` is 1 (ALU result). In step 1, `rf_rd`, `st_drive` and `rf_wr` (base update) are high.
- R5: A load spends three execute cycles. In step 0, `rf_rd` is high and `addr_sel` is 1. In step 1, only `ld_capture` is high. In step 2, only `rf_wr` is high.
- R6: A branch of either class spends three execute cycles. In step 0, `flush` and `addr_sel` are high and `pc` loads `tgt_addr`. The instructions in fetch and decode are invalidated on the following edge.
- R7: While execute holds a load or store that is short of its last step, or a branch in step 0, `in_ready` is 0 and the fetch and decode stages and `pc` hold. In branch steps 1 and 2, `in_ready` is 1 so that the refill can proceed.
- R8: For branch-with-link, step 1 raises `lr_wr` and copies `pc` into `lr_val`. Step 2 raises `lr_fix` and reduces `lr_val` by 4. A plain branch raises neither strobe and leaves `lr_val` unchanged.
- R9: `pc_inc` is high exactly when a word is accepted, and then `pc` advances by 4 on that edge.
- R10: `in_ready` does not depend on `in_valid`. When `in_ready` is 1 and `in_valid` is 0, fetch becomes empty on the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Fetched word is present |
| in_ready | output | 1 | Fetch stage accepts a word this cycle |
| in_class | input | 3 | Instruction class code |
| in_word | input | IW | Fetched instruction word |
| tgt_addr | input | AW | Branch target from the datapath |
| f_vld | output | 1 | Fetch stage holds an instruction |
| d_vld | output | 1 | Decode stage holds an instruction |
| e_vld | output | 1 | Execute stage holds an instruction |
| e_step | output | 2 | Execute cycle index of the current instruction |
| e_word | output | IW | Word of the instruction in execute |
| rf_rd | output | 1 | Register-file read enable |
| rf_wr | output | 1 | Register-file write enable |
| addr_sel | output | 1 | Address register source: 0 incrementer, 1 ALU |
| flush | output | 1 | Invalidate fetch and decode |
| st_drive | output | 1 | Drive store data to memory |
| ld_capture | output | 1 | Capture memory data into the data-in register |
| lr_wr | output | 1 | Save return address into the link register |
| lr_fix | output | 1 | Apply link correction |
| pc_inc | output | 1 | PC advances this cycle |
| pc | output | AW | Next fetch address |
| lr_val | output | AW | Link value |

## Verification
The sweep runs every ordered pair of class codes through the pipeline, with and without gaps in `in_valid`. This covers a long instruction followed by another long one, and a branch squashing a load or store that is already in flight. A sequencer that counted a step too few or too many would shift every later strobe and execute entry by a cycle. One that forgot to squash would run the two instructions behind a branch. One that froze fetch through the whole branch would take too long to refill and would leave `pc` off by the refill fetches. The link path is checked for both branch classes, so a correction applied to a plain branch, or applied to the wrong PC sample, shows up in `lr_val`. Codes 5 to 7 confirm the fallback to ALU timing.

// File: rtl/pseq_pkg.sv
package pseq_pkg;

  localparam int MAX_STEPS = 3;
  localparam int STEP_W    = $clog2(MAX_STEPS);

  typedef enum logic [2:0] {
    CL_ALU   = 3'd0,
    CL_LOAD  = 3'd1,
    CL_STORE = 3'd2,
    CL_BR    = 3'd3,
    CL_BRL   = 3'd4
  } cls_e;

  typedef struct packed {
    logic rd;
    logic wr;
    logic asel;
    logic flush;
    logic st;
    logic ld;
    logic lrw;
    logic lrf;
    logic pcld;
  } strobe_t;

  // unknown codes fall back to single-cycle ALU handling
  function automatic cls_e to_cls(input logic [2:0] raw);
    case (raw)
      3'd1:    return CL_LOAD;
      3'd2:    return CL_STORE;
      3'd3:    return CL_BR;
      3'd4:    return CL_BRL;
      default: return CL_ALU;
    endcase
  endfunction

  function automatic logic is_branch(input cls_e c);
    return (c == CL_BR) || (c == CL_BRL);
  endfunction

  function automatic logic [STEP_W-1:0] final_step(input cls_e c);
    case (c)
      CL_ALU:   return STEP_W'(0);
      CL_STORE: return STEP_W'(1);
      default:  return STEP_W'(MAX_STEPS - 1);
    endcase
  endfunction

endpackage

// File: rtl/pseq_front.sv
module pseq_front
  import pseq_pkg::*;
#(
  parameter int IW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          go,
  input  logic          squash,
  input  logic          in_valid,
  input  cls_e          in_cls,
  input  logic [IW-1:0] in_word,
  output logic          f_vld,
  output cls_e          f_cls,
  output logic [IW-1:0] f_word,
  output logic          d_vld,
  output cls_e          d_cls,
  output logic [IW-1:0] d_word
);

  always_ff @(posedge clk) begin
    if (rst) begin
      f_vld  <= 1'b0;
      d_vld  <= 1'b0;
      f_cls  <= CL_ALU;
      d_cls  <= CL_ALU;
      f_word <= '0;
      d_word <= '0;
    end else if (squash) begin
      f_vld <= 1'b0;
      d_vld <= 1'b0;
    end else if (go) begin
      d_vld  <= f_vld;
      d_cls  <= f_cls;
      d_word <= f_word;
      f_vld  <= in_valid;
      f_cls  <= in_cls;
      f_word <= in_word;
    end
  end

  // R6
  squash_clear_chk: assert property (@(posedge clk) disable iff (rst)
    squash |=> (!f_vld && !d_vld));

  // R7
  front_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!go && !squash) |=> ($stable(f_vld) && $stable(d_vld) && $stable(f_word) && $stable(d_word)));

endmodule

// File: rtl/pseq_exec.sv
module pseq_exec
  import pseq_pkg::*;
#(
  parameter int IW = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              d_vld,
  input  cls_e              d_cls,
  input  logic [IW-1:0]     d_word,
  output logic              e_vld,
  output cls_e              e_cls,
  output logic [IW-1:0]     e_word,
  output logic [STEP_W-1:0] e_step,
  output logic              front_go,
  output logic              squash,
  output strobe_t           sb
);

  logic at_end;
  logic take;

  assign at_end   = e_vld && (e_step == final_step(e_cls));
  assign take     = !e_vld || at_end;
  assign squash   = e_vld && is_branch(e_cls) && (e_step == '0);
  assign front_go = take || (e_vld && is_branch(e_cls) && (e_step != '0));

  always_ff @(posedge clk) begin
    if (rst) begin
      e_vld  <= 1'b0;
      e_cls  <= CL_ALU;
      e_word <= '0;
      e_step <= '0;
    end else if (take) begin
      e_vld  <= d_vld;
      e_cls  <= d_cls;
      e_word <= d_word;
      e_step <= '0;
    end else begin
      e_step <= e_step + 1'b1;
    end
  end

  always_comb begin
    sb = '0;
    if (e_vld) begin
      case (e_cls)
        CL_STORE: begin
          sb.rd = 1'b1;
          if (e_step == '0) sb.asel = 1'b1;
          else begin
            sb.st = 1'b1;
            sb.wr = 1'b1;
          end
        end
        CL_LOAD: begin
          case (e_step)
            STEP_W'(0): begin sb.rd = 1'b1; sb.asel = 1'b1; end
            STEP_W'(1): sb.ld = 1'b1;
            default:    sb.wr = 1'b1;
          endcase
        end
        CL_BR, CL_BRL: begin
          case (e_step)
            STEP_W'(0): begin sb.flush = 1'b1; sb.asel = 1'b1; sb.pcld = 1'b1; end
            STEP_W'(1): sb.lrw = (e_cls == CL_BRL);
            default:    sb.lrf = (e_cls == CL_BRL);
          endcase
        end
        default: begin
          sb.rd = 1'b1;
          sb.wr = 1'b1;
        end
      endcase
    end
  end

  // R4
  store_len_chk: assert property (@(posedge clk) disable iff (rst)
    (e_vld && e_cls == CL_STORE && e_step == '0) |=> (e_vld && e_cls == CL_STORE && e_step == STEP_W'(1)));

  // R5
  load_len_chk: assert property (@(posedge clk) disable iff (rst)
    (e_vld && e_cls == CL_LOAD && e_step == STEP_W'(1)) |=> (e_vld && e_cls == CL_LOAD && e_step == STEP_W'(2)));

  // R6
  branch_len_chk: assert property (@(posedge clk) disable iff (rst)
    (e_vld && is_branch(e_cls) && e_step == STEP_W'(1)) |=> (e_vld && $stable(e_cls) && e_step == STEP_W'(2)));

  // R3
  alu_single_chk: assert property (@(posedge clk) disable iff (rst)
    (e_vld && e_cls == CL_ALU) |-> (e_step == '0));

endmodule

// File: rtl/pseq_pc.sv
module pseq_pc #(
  parameter int AW       = 32,
  parameter int PC_STEP  = 4,
  parameter int LINK_ADJ = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          inc,
  input  logic          load,
  input  logic [AW-1:0] tgt,
  input  logic          lr_cap,
  input  logic          lr_adj,
  output logic [AW-1:0] pc,
  output logic [AW-1:0] lr
);

  localparam logic [AW-1:0] STEP_V = AW'(PC_STEP);
  localparam logic [AW-1:0] ADJ_V  = AW'(LINK_ADJ);

  always_ff @(posedge clk) begin
    if (rst) begin
      pc <= '0;
      lr <= '0;
    end else begin
      if (load)     pc <= tgt;
      else if (inc) pc <= pc + STEP_V;
      if (lr_cap)      lr <= pc;
      else if (lr_adj) lr <= lr - ADJ_V;
    end
  end

  // R9
  pc_step_chk: assert property (@(posedge clk) disable iff (rst)
    (inc && !load) |=> (pc == $past(pc) + STEP_V));

  // R6
  pc_load_chk: assert property (@(posedge clk) disable iff (rst)
    load |=> (pc == $past(tgt)));

  // R8
  lr_adj_chk: assert property (@(posedge clk) disable iff (rst)
    lr_adj |=> (lr == $past(lr) - ADJ_V));

  // R7
  pc_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!inc && !load) |=> $stable(pc));

endmodule

// File: rtl/pipe_seq.sv
module pipe_seq
  import pseq_pkg::*;
#(
  parameter int IW       = 16,
  parameter int AW       = 32,
  parameter int PC_STEP  = 4,
  parameter int LINK_ADJ = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [2:0]    in_class,
  input  logic [IW-1:0] in_word,
  input  logic [AW-1:0] tgt_addr,
  output logic          f_vld,
  output logic          d_vld,
  output logic          e_vld,
  output logic [1:0]    e_step,
  output logic [IW-1:0] e_word,
  output logic          rf_rd,
  output logic          rf_wr,
  output logic          addr_sel,
  output logic          flush,
  output logic          st_drive,
  output logic          ld_capture,
  output logic          lr_wr,
  output logic          lr_fix,
  output logic          pc_inc,
  output logic [AW-1:0] pc,
  output logic [AW-1:0] lr_val
);

  cls_e              in_cls, f_cls, d_cls, e_cls;
  logic [IW-1:0]     f_word, d_word;
  logic [STEP_W-1:0] step_q;
  logic              go, squash;
  strobe_t           sb;

  assign in_cls = to_cls(in_class);

  pseq_front #(.IW(IW)) u_front (
    .clk(clk), .rst(rst), .go(go), .squash(squash),
    .in_valid(in_valid), .in_cls(in_cls), .in_word(in_word),
    .f_vld(f_vld), .f_cls(f_cls), .f_word(f_word),
    .d_vld(d_vld), .d_cls(d_cls), .d_word(d_word)
  );

  pseq_exec #(.IW(IW)) u_exec (
    .clk(clk), .rst(rst),
    .d_vld(d_vld), .d_cls(d_cls), .d_word(d_word),
    .e_vld(e_vld), .e_cls(e_cls), .e_word(e_word), .e_step(step_q),
    .front_go(go), .squash(squash), .sb(sb)
  );

  pseq_pc #(.AW(AW), .PC_STEP(PC_STEP), .LINK_ADJ(LINK_ADJ)) u_pc (
    .clk(clk), .rst(rst),
    .inc(pc_inc), .load(sb.pcld), .tgt(tgt_addr),
    .lr_cap(sb.lrw), .lr_adj(sb.lrf),
    .pc(pc), .lr(lr_val)
  );

  assign in_ready   = go;
  assign pc_inc     = in_valid && go;
  assign e_step     = 2'(step_q);
  assign rf_rd      = sb.rd;
  assign rf_wr      = sb.wr;
  assign addr_sel   = sb.asel;
  assign flush      = sb.flush;
  assign st_drive   = sb.st;
  assign ld_capture = sb.ld;
  assign lr_wr      = sb.lrw;
  assign lr_fix     = sb.lrf;

  // R7
  load_stall_chk: assert property (@(posedge clk) disable iff (rst)
    ld_capture |-> !in_ready);

  // R2
  fetch_fill_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready) |=> f_vld);

  // R10
  fetch_bubble_chk: assert property (@(posedge clk) disable iff (rst)
    (!in_valid && in_ready) |=> !f_vld);

endmodule

// File: tb/sim_pipe_seq.sv
`timescale 1ns/1ps
module sim_pipe_seq;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [2:0]  in_class = 3'd0;
  logic [15:0] in_word = '0;
  logic [31:0] tgt_addr = '0;
  logic        in_ready, f_vld, d_vld, e_vld;
  logic [1:0]  e_step;
  logic [15:0] e_word;
  logic        rf_rd, rf_wr, addr_sel, flush, st_drive, ld_capture, lr_wr, lr_fix, pc_inc;
  logic [31:0] pc, lr_val;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #2 clk = ~clk;

  pipe_seq u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_class(in_class), .in_word(in_word), .tgt_addr(tgt_addr),
    .f_vld(f_vld), .d_vld(d_vld), .e_vld(e_vld), .e_step(e_step), .e_word(e_word),
    .rf_rd(rf_rd), .rf_wr(rf_wr), .addr_sel(addr_sel), .flush(flush),
    .st_drive(st_drive), .ld_capture(ld_capture), .lr_wr(lr_wr), .lr_fix(lr_fix),
    .pc_inc(pc_inc), .pc(pc), .lr_val(lr_val)
  );

  // reference model state
  bit          mfv, mdv, mev;
  int          mfc, mdc, mec, mstep;
  logic [15:0] mfw, mdw, mew;
  logic [31:0] mpc, mlr;

  function automatic int norm(input int c);
    return (c >= 1 && c <= 4) ? c : 0;
  endfunction

  function automatic int steps_of(input int c);
    return (c == 2) ? 2 : (c == 0) ? 1 : 3;
  endfunction

  function automatic bit m_go();
    bit last;
    last = mev && (mstep == steps_of(mec) - 1);
    return !mev || last || (mev && mec >= 3 && mstep != 0);
  endfunction

  function automatic logic [7:0] m_strobes();
    if (!mev) return 8'h00;
    case (mec)
      0: return 8'b1100_0000;
      2: return (mstep == 0) ? 8'b1010_0000 : 8'b1100_1000;
      1: return (mstep == 0) ? 8'b1010_0000 : (mstep == 1) ? 8'b0000_0100 : 8'b0100_0000;
      default: begin
        if (mstep == 0) return 8'b0011_0000;
        if (mec == 4) return (mstep == 1) ? 8'b0000_0010 : 8'b0000_0001;
        return 8'h00;
      end
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compare();
    logic [7:0] es, ds;
    string st;
    es = m_strobes();
    ds = {rf_rd, rf_wr, addr_sel, flush, st_drive, ld_capture, lr_wr, lr_fix};
    case (mec)
      1: st = "R5 load strobes";
      2: st = "R4 store strobes";
      3: st = "R6 branch strobes";
      4: st = "R8 link strobes";
      default: st = "R3 alu strobes";
    endcase
    if (!mev) st = "R2 idle strobes";
    check(ds == es, st, 32'(ds), 32'(es));
    check({f_vld, d_vld, e_vld} == {mfv, mdv, mev}, "R2 stage valid", 32'({f_vld, d_vld, e_vld}), 32'({mfv, mdv, mev}));
    if (mev) begin
      check(e_word == mew, "R2 execute word", 32'(e_word), 32'(mew));
      check(e_step == 2'(mstep), "R2 execute step", 32'(e_step), 32'(mstep));
    end
    check(in_ready == m_go(), mev ? "R7 ready" : "R10 ready", 32'(in_ready), 32'(m_go()));
    check(pc_inc == (in_valid && m_go()), "R9 pc_inc", 32'(pc_inc), 32'(in_valid && m_go()));
    check(pc == mpc, "R9 pc", pc, mpc);
    check(lr_val == mlr, "R8 link value", lr_val, mlr);
  endtask

  task automatic model_edge();
    bit go, sq, take;
    go   = m_go();
    sq   = mev && mec >= 3 && mstep == 0;
    take = !mev || (mstep == steps_of(mec) - 1);
    if (mev && mec == 4 && mstep == 1) mlr = mpc;
    else if (mev && mec == 4 && mstep == 2) mlr = mlr - 32'd4;
    if (sq) mpc = tgt_addr;
    else if (in_valid && go) mpc = mpc + 32'd4;
    if (take) begin
      mev = mdv; mec = mdc; mew = mdw; mstep = 0;
    end else mstep++;
    if (sq) begin
      mfv = 0; mdv = 0;
    end else if (go) begin
      mdv = mfv; mdc = mfc; mdw = mfw;
      mfv = in_valid; mfc = norm(int'(in_class)); mfw = in_word;
    end
  endtask

  // one cycle: drive after negedge, compare, then advance the model at the edge
  task automatic cyc(input bit v, input int c, input logic [15:0] w, input logic [31:0] t, output bit acc);
    @(negedge clk);
    in_valid = v; in_class = 3'(c); in_word = w; tgt_addr = t;
    #1;
    compare();
    acc = v && m_go();
    @(posedge clk);
    model_edge();
  endtask

  task automatic push(input int c, input logic [15:0] w, input logic [31:0] t);
    bit acc;
    acc = 0;
    while (!acc) cyc(1'b1, c, w, t, acc);
  endtask

  task automatic idle(input int n);
    bit acc;
    for (int i = 0; i < n; i++) cyc(1'b0, 0, 16'h0, 32'h0, acc);
  endtask

  initial begin
    logic [15:0] wid;
    logic [15:0] lf;
    bit acc;
    mfv = 0; mdv = 0; mev = 0; mfc = 0; mdc = 0; mec = 0; mstep = 0;
    mfw = '0; mdw = '0; mew = '0; mpc = '0; mlr = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R1 reset state
    check(!f_vld && !d_vld && !e_vld, "R1 stage valid in reset", 32'({f_vld, d_vld, e_vld}), 0);
    check(pc == 0 && lr_val == 0, "R1 pc and link in reset", pc, 0);
    check({rf_rd, rf_wr, addr_sel, flush, st_drive, ld_capture, lr_wr, lr_fix} == 0, "R1 strobes in reset",
          32'({rf_rd, rf_wr, addr_sel, flush, st_drive, ld_capture, lr_wr, lr_fix}), 0);
    check(in_ready == 1'b1, "R1 ready in reset", 32'(in_ready), 1);
    rst = 1'b0;
    @(posedge clk);
    #1;
    check(!e_vld && pc == 0, "R1 state after release", pc, 0);

    // R2 latency: first word reaches execute on the third edge
    cyc(1'b1, 0, 16'hA001, 32'h0, acc);
    cyc(1'b1, 0, 16'hA002, 32'h0, acc);
    cyc(1'b1, 0, 16'hA003, 32'h0, acc);
    #1;
    check(e_vld && e_word == 16'hA001, "R2 latency three", 32'(e_word), 32'hA001);
    idle(4);

    // near-exhaustive sweep over class pairs, with and without gaps
    wid = 16'h0100;
    for (int g = 0; g < 2; g++) begin
      for (int a = 0; a < 8; a++) begin
        for (int b = 0; b < 8; b++) begin
          push(a, wid, 32'h1000 + 32'(a * 256 + b * 16)); wid++;
          if (g != 0) idle(1);
          push(b, wid, 32'h8000 + 32'(b * 64)); wid++;
          push(0, wid, 32'h0); wid++;
          idle(6);
        end
      end
    end

    // pseudo-random stream
    lf = 16'hACE1;
    for (int i = 0; i < 600; i++) begin
      lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
      cyc(lf[0] | lf[1], int'(lf[4:2]), lf, {16'h0, lf} & 32'hFFFC, acc);
    end
    idle(6);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule